// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block collects up to 32 level-sensitive peripheral interrupt sources and steers each one onto one of nine prioritized core request lines, numbered 0 (highest priority) to 8 (lowest). Every source owns a 4-bit routing field, and eight fields are packed into each of four routing registers. Software can rewrite any field at any time to move a source to another line, and so change its effective priority. A field value above 8 leaves the source unrouted.

A small register port holds the routing registers, an enable mask, a wakeup-enable register and a read-only view of the raw source levels. The enable mask gates the core request lines. The wakeup-enable register gates a separate wakeup request, which ignores the mask. For convenience the block also reports the index of the highest-priority active core line. The routing registers reset to an uneven default grouping that leaves lines 5 to 8 unused. Lines 7 and 8 are meant for software handlers, but sources can still be routed to them.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, routing registers 0..3 read 0x00000000, 0x11000000, 0x33332222 and 0x44444433. Sources 0–13 go to line 0, sources 14–15 to line 1, sources 16–19 to line 2, sources 20–25 to line 3 and sources 26–31 to line 4. The mask and wakeup-enable registers read 0.
- R2: Register addresses are: 0..3 routing registers, 4 enable mask, 5 raw status, 6 wakeup enable. Routing register r holds the field of source 8r+k at bits 4k+3..4k. The registers at addresses 0–4 and 6 read back what was last written to them. Reads are combinational.
- R3: A field value v in 0..8 drives core_req bit v, which is core line v, when the source is active and enabled.
- R4: A field value from 9 to 15 routes its source to no core line.
- R5: Each core_req bit is the OR of all sources that are at level 1, have mask bit 1 and are routed to that line. The bit appears one clock after the inputs that cause it.
- R6: Address 5 returns the raw source levels whatever the mask is. Writes to address 5 change no register.
- R7: wake_req is the OR of the source levels ANDed with the wakeup-enable bits, independent of the mask. It appears one clock after its inputs.
- R8: top_line is the lowest set bit index of core_req, and 15 when core_req is 0. It changes in the same cycle as core_req.
- R9: A routing write takes effect in the core_req value registered on the clock after the write edge.
- R10: Address 7 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_src | input | 32 | Peripheral interrupt levels, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| core_req | output | 9 | Registered core request lines, bit 0 highest priority |
| wake_req | output | 1 | Registered wakeup request |
| top_line | output | 4 | Index of highest-priority active core line, 15 if none |

## Verification
The hardest case to reach from the ports is a live remap. A source already asserted and enabled has to move between lines, including into the two lowest lines and the unrouted codes. The core output must show the old line for exactly one more cycle and then the new one. The stimulus holds one high source steady and steps its routing field through all nine line codes and two unrouted codes. One step is sampled right after the write edge and again one cycle later to pin the latency. Mask and wakeup paths are then set against each other with the same source pattern.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SRC_N       = 32;
  localparam int LINE_N      = 9;
  localparam int FLD_W       = 4;
  localparam int FLD_PER_REG = 8;
  localparam int ASG_N       = SRC_N / FLD_PER_REG;
  localparam int DATA_W      = FLD_W * FLD_PER_REG;
  localparam int ADDR_W      = 3;
  localparam int IDX_W       = 4;

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ASG_N);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ASG_N + 1);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(ASG_N + 2);
  localparam logic [IDX_W-1:0]  NO_LINE = '1;

  function automatic logic [FLD_W-1:0] reset_route(input int id);
    if (id < 14)      return FLD_W'(0);
    else if (id < 16) return FLD_W'(1);
    else if (id < 20) return FLD_W'(2);
    else if (id < 26) return FLD_W'(3);
    else              return FLD_W'(4);
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int P_SRC_N = SRC_N,
  parameter int P_FLD_W = FLD_W,
  parameter int P_FPR   = FLD_PER_REG,
  parameter int P_AW    = ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [P_AW-1:0]            addr,
  input  logic [P_FLD_W*P_FPR-1:0]   wdata,
  input  logic [P_SRC_N-1:0]         src_lvl,
  output logic [P_FLD_W*P_FPR-1:0]   rdata,
  output logic [P_SRC_N*P_FLD_W-1:0] asg_flat,
  output logic [P_SRC_N-1:0]         mask,
  output logic [P_SRC_N-1:0]         wake_en
);
  localparam int DW   = P_FLD_W * P_FPR;
  localparam int NREG = P_SRC_N / P_FPR;
  localparam int RIW  = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][DW-1:0] asg_q, asg_d;
  logic [NREG-1:0]         asg_en;
  logic [P_SRC_N-1:0]      mask_q, mask_d, wake_q, wake_d;
  logic                    mask_en, wake_en_w;

  // next-state
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      asg_en[r] = wr_en && (addr == P_AW'(r));
      asg_d[r]  = asg_en[r] ? wdata : asg_q[r];
    end
    mask_en   = wr_en && (addr == A_MASK);
    wake_en_w = wr_en && (addr == A_WAKE);
    mask_d    = mask_en   ? wdata[P_SRC_N-1:0] : mask_q;
    wake_d    = wake_en_w ? wdata[P_SRC_N-1:0] : wake_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int f = 0; f < P_FPR; f++)
          asg_q[r][f*P_FLD_W +: P_FLD_W] <= reset_route(r*P_FPR + f);
      mask_q <= '0;
      wake_q <= '0;
    end else begin
      asg_q  <= asg_d;
      mask_q <= mask_d;
      wake_q <= wake_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    if (int'(addr) < NREG) rdata = asg_q[addr[RIW-1:0]];
    else if (addr == A_MASK) rdata[P_SRC_N-1:0] = mask_q;
    else if (addr == A_STAT) rdata[P_SRC_N-1:0] = src_lvl;
    else if (addr == A_WAKE) rdata[P_SRC_N-1:0] = wake_q;
  end

  assign asg_flat = asg_q;
  assign mask     = mask_q;
  assign wake_en  = wake_q;

  // R6
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ($stable(mask_q) && $stable(wake_q) && $stable(asg_q)));

  // R10
  hole_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == P_AW'(NREG + 3)) |=> ($stable(mask_q) && $stable(wake_q) && $stable(asg_q)));
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irq_route_pkg::*;
#(
  parameter int P_SRC_N  = SRC_N,
  parameter int P_LINE_N = LINE_N,
  parameter int P_FLD_W  = FLD_W
) (
  input  logic [P_SRC_N-1:0]         src_lvl,
  input  logic [P_SRC_N-1:0]         mask,
  input  logic [P_SRC_N*P_FLD_W-1:0] asg_flat,
  output logic [P_LINE_N-1:0]        line_hit
);
  logic [P_SRC_N-1:0][P_LINE_N-1:0] sel;

  for (genvar s = 0; s < P_SRC_N; s++) begin : g_src
    logic [P_FLD_W-1:0] fld;
    assign fld = asg_flat[s*P_FLD_W +: P_FLD_W];
    for (genvar l = 0; l < P_LINE_N; l++) begin : g_line
      assign sel[s][l] = src_lvl[s] && mask[s] && (fld == P_FLD_W'(l));
    end
  end

  always_comb begin
    line_hit = '0;
    for (int s = 0; s < P_SRC_N; s++) line_hit = line_hit | sel[s];
  end
endmodule

// File: rtl/irq_route_prio.sv
module irq_route_prio
  import irq_route_pkg::*;
#(
  parameter int P_LINE_N = LINE_N,
  parameter int P_IDX_W  = IDX_W
) (
  input  logic [P_LINE_N-1:0] req,
  output logic [P_IDX_W-1:0]  idx
);
  always_comb begin
    idx = '1;
    for (int l = P_LINE_N - 1; l >= 0; l--)
      if (req[l]) idx = P_IDX_W'(l);
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_N-1:0]    irq_src,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [LINE_N-1:0]   core_req,
  output logic                wake_req,
  output logic [IDX_W-1:0]    top_line
);
  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  logic [SRC_N*FLD_W-1:0]  asg_flat;
  logic [SRC_N-1:0]        mask, wake_en;
  logic [LINE_N-1:0]       line_hit, req_q, req_d;
  logic                    wake_q, wake_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_route_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .src_lvl(irq_src), .rdata(reg_rdata),
    .asg_flat(asg_flat), .mask(mask), .wake_en(wake_en)
  );

  irq_route_xbar u_xbar (
    .src_lvl(irq_src), .mask(mask), .asg_flat(asg_flat), .line_hit(line_hit)
  );

  // next-state
  always_comb begin
    req_d  = line_hit;
    wake_d = |(irq_src & wake_en);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      wake_q <= wake_d;
    end
  end

  irq_route_prio u_prio (.req(req_q), .idx(top_line));

  assign core_req = req_q;
  assign wake_req = wake_q;

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == '0) |=> (core_req == '0));

  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wake_en == '0) |=> !wake_req);

  // R8
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (core_req == '0) |-> (top_line == NO_LINE));

  // R8
  top_hit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (core_req != '0) |-> ((((core_req >> top_line) & LINE_N'(1)) == LINE_N'(1)) &&
                          ((core_req & ((LINE_N'(1) << top_line) - LINE_N'(1))) == '0)));

  // R6
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr == A_STAT) |-> (reg_rdata == irq_src));
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_src;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [8:0]  core_req;
  logic        wake_req;
  logic [3:0]  top_line;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_req(core_req), .wake_req(wake_req), .top_line(top_line)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_out(input logic [8:0] req, input logic [3:0] top, input string tag);
    check({tag, " core_req"}, {23'd0, core_req}, {23'd0, req});
    check({tag, " top_line"}, {28'd0, top_line}, {28'd0, top});
  endtask

  task automatic t_reset();
    rd(3'd0, 32'h0000_0000, "R1 reg0");
    rd(3'd1, 32'h1100_0000, "R1 reg1");
    rd(3'd2, 32'h3333_2222, "R1 reg2");
    rd(3'd3, 32'h4444_4433, "R1 reg3");
    rd(3'd4, 32'h0, "R1 mask");
    rd(3'd6, 32'h0, "R1 wake_en");
    chk_out(9'h000, 4'hF, "R1 idle");
    check("R1 wake_req", {31'd0, wake_req}, 32'd0);
  endtask

  task automatic t_regs();
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, 32'h1234_5678, "R2 mask readback");
    wr(3'd6, 32'h8765_4321);
    rd(3'd6, 32'h8765_4321, "R2 wake readback");
    wr(3'd0, 32'h9876_5432);
    rd(3'd0, 32'h9876_5432, "R2 reg0 readback");
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0);
  endtask

  task automatic t_default_route();
    wr(3'd4, 32'hFFFF_FFFF);
    irq_src = 32'h0000_0001; settle(); chk_out(9'h001, 4'd0, "R1 src0");
    irq_src = 32'h0000_8000; settle(); chk_out(9'h002, 4'd1, "R1 src15");
    irq_src = 32'h0004_0000; settle(); chk_out(9'h004, 4'd2, "R1 src18");
    irq_src = 32'h0040_0000; settle(); chk_out(9'h008, 4'd3, "R1 src22");
    irq_src = 32'h4000_0000; settle(); chk_out(9'h010, 4'd4, "R5 src30");
    irq_src = 32'h4000_0001; settle(); chk_out(9'h011, 4'd0, "R5 or of lines");
  endtask

  task automatic t_remap();
    irq_src = 32'h8000_0000;
    for (int l = 0; l < 8; l++) begin
      wr(3'd3, {4'(l), 28'h444_4433});
      settle();
      chk_out(9'h001 << l, 4'(l), "R3 remap");
    end
    wr(3'd3, {4'd8, 28'h444_4433});
    chk_out(9'h080, 4'd7, "R9 old line one cycle");
    @(negedge clk);
    chk_out(9'h100, 4'd8, "R9 new line");
  endtask

  task automatic t_unrouted();
    irq_src = 32'h8000_0000;
    wr(3'd3, {4'd9, 28'h444_4433});
    settle(); chk_out(9'h000, 4'hF, "R4 field 9");
    wr(3'd3, {4'hF, 28'h444_4433});
    settle(); chk_out(9'h000, 4'hF, "R4 field 15");
    wr(3'd3, 32'h4444_4433);
  endtask

  task automatic t_mask();
    wr(3'd4, 32'h0);
    irq_src = 32'hFFFF_FFFF; settle(); chk_out(9'h000, 4'hF, "R5 all masked");
    wr(3'd4, 32'h0001_0000);
    settle(); chk_out(9'h004, 4'd2, "R5 one enabled");
    wr(3'd4, 32'h0000_0001);
    irq_src = 32'h0000_0002; settle(); chk_out(9'h000, 4'hF, "R5 enabled but idle");
  endtask

  task automatic t_status();
    wr(3'd4, 32'h0);
    irq_src = 32'hA5A5_5A5A;
    rd(3'd5, 32'hA5A5_5A5A, "R6 raw with mask 0");
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0, "R6 write ignored mask");
    rd(3'd6, 32'h0, "R6 write ignored wake");
    rd(3'd5, 32'hA5A5_5A5A, "R6 raw after write");
  endtask

  task automatic t_wake();
    wr(3'd4, 32'h0);
    wr(3'd6, 32'h0000_0008);
    irq_src = 32'h0000_0008; settle();
    check("R7 wake set", {31'd0, wake_req}, 32'd1);
    chk_out(9'h000, 4'hF, "R7 no core when masked");
    irq_src = 32'h0000_0010; settle();
    check("R7 other source", {31'd0, wake_req}, 32'd0);
    irq_src = 32'h0000_0008;
    wr(3'd6, 32'h0); settle();
    check("R7 disabled", {31'd0, wake_req}, 32'd0);
  endtask

  task automatic t_prio();
    wr(3'd4, 32'hFFFF_FFFF);
    irq_src = 32'h0040_8000; settle(); chk_out(9'h00A, 4'd1, "R8 line1 wins");
    wr(3'd4, 32'hFFFF_7FFF);
    settle(); chk_out(9'h008, 4'd3, "R8 line3 after mask");
  endtask

  task automatic t_hole();
    wr(3'd4, 32'h0000_0001);
    irq_src = 32'h0000_0001; settle();
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, 32'h0, "R10 hole reads zero");
    rd(3'd4, 32'h0000_0001, "R10 mask kept");
    rd(3'd0, 32'h0, "R10 reg0 kept");
    settle(); chk_out(9'h001, 4'd0, "R10 routing kept");
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_src = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_default_route();
    t_remap();
    t_unrouted();
    t_mask();
    t_status();
    t_wake();
    t_prio();
    t_hole();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule